// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic stage of a small register machine. Each cycle it takes two 8-bit operands, an incoming carry, an operation select and the current 8-bit status word. It returns the result, the updated status word and a write-enable flag that says whether the result should be written back to a register. Each operation changes only the status bits that belong to it. Every other status bit passes through unchanged.

The status word layout is fixed, from bit 7 down to bit 0: I, T, H, S, V, N, Z, C. I and T belong to the rest of the machine. The ALU never alters them. All outputs are registered, so results and flags appear one clock after the operands are presented.

Top module: `alu8_core`

## Requirements
- R1: All outputs are registered with one cycle of latency. A synchronous active-high reset clears `result_q`, `status_q` and `wr_en_q` to zero.
- R2: Status bits 7 (I) and 6 (T) of `status_q` always equal the `status_in` bits presented with the operation.
- R3: Select 0 (add) forms A+B. Select 1 (add with carry) forms A+B+`carry_in`. For both: C (bit 0) is the carry out of bit 7 and H (bit 5) is the carry out of bit 3. V (bit 3) is set when both operands have the same sign and the result sign differs. N (bit 2) is result bit 7, Z (bit 1) is set for a zero result, and S (bit 4) is N XOR V.
- R4: Select 2 (subtract) forms A-B, and select 3 (subtract with carry) forms A-B-`carry_in`. C is the borrow out of bit 7 and H is the borrow out of bit 3. V is set when the operand signs differ and the result sign differs from A. N, Z and S follow the rules of R3.
- R5: For select 3 and select 5 (compare with carry), a non-zero result clears Z. A zero result leaves Z at its incoming value.
- R6: Select 4 (compare, A-B) and select 5 (compare with carry, A-B-`carry_in`) update the flags exactly as subtraction does. They present the difference on the result and drive `wr_en_q` low. Every other valid select drives it high.
- R7: Selects 6 (AND), 7 (OR) and 8 (XOR) force V to 0, set S, N and Z from the result, and keep H and C.
- R8: Select 9 (one's complement of A) forces C to 1 and V to 0, sets S, N and Z, and keeps H.
- R9: Select 10 (negate) yields 0-A. C is set when the result is non-zero, and V is set only when the result is 0x80. H is the borrow out of bit 3, and S, N and Z follow the result.
- R10: Select 11 (increment A) sets V only when A was 0x7F. Select 12 (decrement A) sets V only when A was 0x80. Both set S, N and Z and keep C and H.
- R11: Selects 14 (arithmetic shift right, bit 7 kept), 15 (logical shift right, 0 into bit 7) and 16 (rotate right, `carry_in` into bit 7) move A bit 0 into C. They set V to N XOR C and set S, N and Z; H is kept.
- R12: Select 13 exchanges the high and low nibbles of A and leaves the whole status word unchanged.
- R13: Select codes 17 to 31 give a zero result, pass the status word through unchanged and drive `wr_en_q` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation select |
| opnd_a | input | 8 | First operand (minuend, sole operand of unary ops) |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry for carry-chained ops and rotate |
| status_in | input | 8 | Current status word |
| result_q | output | 8 | Registered result |
| status_q | output | 8 | Registered updated status word |
| wr_en_q | output | 1 | Registered result write-back enable |

## Verification
The hardest case to reach is zero-flag chaining across a multi-byte compare. A zero result must keep the incoming Z rather than set it, and that difference shows only when the incoming Z is clear and the byte difference is exactly zero. The stimulus table therefore repeats one zero-difference subtract-with-carry twice: once with Z set on entry and once with Z clear. It also adds a non-zero case that must clear a set Z. Signed-overflow edges are reached the same way, with operands chosen to cross 0x7F/0x80, so that V and S move while C does not.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 5;
  localparam int SR_W = 8;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC = 5'd3,
    OP_CMP  = 5'd4,  OP_CMPC = 5'd5,  OP_AND  = 5'd6,  OP_OR  = 5'd7,
    OP_XOR  = 5'd8,  OP_COM  = 5'd9,  OP_NEG  = 5'd10, OP_INC = 5'd11,
    OP_DEC  = 5'd12, OP_SWAP = 5'd13, OP_ASR  = 5'd14, OP_LSR = 5'd15,
    OP_ROR  = 5'd16
  } alu_op_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOT} logic_mode_e;
  typedef enum logic [1:0] {SH_ASR, SH_LSR, SH_ROR, SH_RSV} shift_mode_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic              c_eff;
  logic [DATA_W:0]   full;
  logic [HALF_W:0]   low;

  // Subtraction as A + ~B + ~borrow; the carry out is then an inverted borrow.
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign full  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
  assign low   = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, c_eff};

  assign sum_o = full[DATA_W-1:0];
  assign c_o   = full[DATA_W] ^ sub_i;
  assign h_o   = low[HALF_W] ^ sub_i;
  assign v_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic_mode_e       mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    case (mode_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  shift_mode_e       mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o
);
  localparam int MSB = DATA_W - 1;
  logic fill;

  always_comb begin
    case (mode_i)
      SH_ASR:  fill = a_i[MSB];
      SH_ROR:  fill = cin_i;
      default: fill = 1'b0;
    endcase
  end

  assign res_o = {fill, a_i[MSB:1]};
  assign c_o   = a_i[0];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              carry_in,
  input  logic [SR_W-1:0]   status_in,
  output logic [DATA_W-1:0] result_q,
  output logic [SR_W-1:0]   status_q,
  output logic              wr_en_q
);
  localparam int MSB    = DATA_W - 1;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {MSB{1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {MSB{1'b0}}};

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // Shared adder/subtractor; negate runs as 0 - A.
  logic [DATA_W-1:0] as_a, as_b, as_sum;
  logic              as_cin, as_sub, as_c, as_h, as_v;
  assign as_a   = (op == OP_NEG) ? '0 : opnd_a;
  assign as_b   = (op == OP_NEG) ? opnd_a : opnd_b;
  assign as_cin = (op == OP_ADC || op == OP_SBC || op == OP_CMPC) ? carry_in : 1'b0;
  assign as_sub = !(op == OP_ADD || op == OP_ADC);

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_sum), .c_o(as_c), .h_o(as_h), .v_o(as_v)
  );

  logic_mode_e       lg_mode;
  logic [DATA_W-1:0] lg_res;
  always_comb begin
    case (op)
      OP_AND:  lg_mode = LG_AND;
      OP_OR:   lg_mode = LG_OR;
      OP_XOR:  lg_mode = LG_XOR;
      default: lg_mode = LG_NOT;
    endcase
  end

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .mode_i(lg_mode), .a_i(opnd_a), .b_i(opnd_b), .res_o(lg_res)
  );

  shift_mode_e       sh_mode;
  logic [DATA_W-1:0] sh_res;
  logic              sh_c;
  always_comb begin
    case (op)
      OP_ASR:  sh_mode = SH_ASR;
      OP_LSR:  sh_mode = SH_LSR;
      default: sh_mode = SH_ROR;
    endcase
  end

  alu8_shifter #(.DATA_W(DATA_W)) u_shift (
    .mode_i(sh_mode), .a_i(opnd_a), .cin_i(carry_in), .res_o(sh_res), .c_o(sh_c)
  );

  // Sets N, Z, V and S from a result and an overflow bit.
  function automatic logic [SR_W-1:0] put_nzvs(input logic [SR_W-1:0] sr,
                                               input logic [DATA_W-1:0] r,
                                               input logic v);
    logic [SR_W-1:0] o;
    o        = sr;
    o[FLG_N] = r[MSB];
    o[FLG_Z] = (r == '0);
    o[FLG_V] = v;
    o[FLG_S] = r[MSB] ^ v;
    return o;
  endfunction

  logic [DATA_W-1:0] res_c;
  logic [SR_W-1:0]   sr_c;
  logic              we_c;

  always_comb begin
    res_c = '0;
    sr_c  = status_in;
    we_c  = 1'b1;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: begin
        res_c        = as_sum;
        sr_c         = put_nzvs(status_in, as_sum, as_v);
        sr_c[FLG_C]  = as_c;
        sr_c[FLG_H]  = as_h;
        if (op == OP_SBC || op == OP_CMPC)
          sr_c[FLG_Z] = (as_sum == '0) && status_in[FLG_Z];
        if (op == OP_CMP || op == OP_CMPC)
          we_c = 1'b0;
      end
      OP_AND, OP_OR, OP_XOR, OP_COM: begin
        res_c = lg_res;
        sr_c  = put_nzvs(status_in, lg_res, 1'b0);
        if (op == OP_COM)
          sr_c[FLG_C] = 1'b1;
      end
      OP_INC: begin
        res_c = opnd_a + 1'b1;
        sr_c  = put_nzvs(status_in, res_c, opnd_a == MAX_POS);
      end
      OP_DEC: begin
        res_c = opnd_a - 1'b1;
        sr_c  = put_nzvs(status_in, res_c, opnd_a == MIN_NEG);
      end
      OP_SWAP: res_c = {opnd_a[HALF_W-1:0], opnd_a[MSB:HALF_W]};
      OP_ASR, OP_LSR, OP_ROR: begin
        res_c       = sh_res;
        sr_c        = put_nzvs(status_in, sh_res, sh_res[MSB] ^ sh_c);
        sr_c[FLG_C] = sh_c;
      end
      default: we_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      status_q <= '0;
      wr_en_q  <= 1'b0;
    end else begin
      result_q <= res_c;
      status_q <= sr_c;
      wr_en_q  <= we_c;
    end
  end

  AST_IT_KEEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status_q[FLG_I:FLG_T] == $past(status_in[FLG_I:FLG_T])); // R2

  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_ADD || $past(op_sel) == OP_ADC))
      |-> status_q[FLG_S] == (status_q[FLG_N] ^ status_q[FLG_V])); // R3

  AST_Z_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_SBC || $past(op_sel) == OP_CMPC)
      && !$past(status_in[FLG_Z])) |-> !status_q[FLG_Z]); // R5

  AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_CMP || $past(op_sel) == OP_CMPC))
      |-> !wr_en_q); // R6

  AST_LOGIC_KEEP_HC: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == OP_AND || $past(op_sel) == OP_OR
      || $past(op_sel) == OP_XOR))
      |-> (status_q[FLG_H] == $past(status_in[FLG_H])
           && status_q[FLG_C] == $past(status_in[FLG_C]) && !status_q[FLG_V])); // R7

  AST_COM_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == OP_COM)
      |-> (status_q[FLG_C] && !status_q[FLG_V])); // R8

  AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == OP_SWAP) |-> status_q == $past(status_in)); // R12

  AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) > OP_ROR)
      |-> (!wr_en_q && result_q == '0 && status_q == $past(status_in))); // R13
endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_sel = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0, status_in = '0;
  logic       carry_in = 1'b0;
  logic [7:0] result_q, status_q;
  logic       wr_en_q;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry_in(carry_in), .status_in(status_in),
    .result_q(result_q), .status_q(status_q), .wr_en_q(wr_en_q)
  );

  // {req[3:0], op[4:0], a, b, cin, sin, exp_res, exp_sr, exp_we}
  localparam int NV = 25;
  localparam logic [50:0] VECS [NV] = '{
    {4'd3,  5'd0,  8'h3A, 8'h46, 1'b1, 8'hC0, 8'h80, 8'hEC, 1'b1}, // R3 add, carry_in ignored
    {4'd3,  5'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 8'h00, 8'h23, 1'b1}, // R3 add with carry wraps
    {4'd4,  5'd2,  8'h10, 8'h01, 1'b0, 8'hC0, 8'h0F, 8'hE0, 1'b1}, // R4 nibble borrow
    {4'd4,  5'd2,  8'h80, 8'h01, 1'b0, 8'h00, 8'h7F, 8'h38, 1'b1}, // R4 signed overflow
    {4'd5,  5'd3,  8'h05, 8'h05, 1'b1, 8'h02, 8'hFF, 8'h35, 1'b1}, // R5 non-zero clears Z
    {4'd5,  5'd3,  8'h05, 8'h04, 1'b1, 8'h02, 8'h00, 8'h02, 1'b1}, // R5 zero keeps Z=1
    {4'd5,  5'd3,  8'h05, 8'h04, 1'b1, 8'h00, 8'h00, 8'h00, 1'b1}, // R5 zero keeps Z=0
    {4'd6,  5'd4,  8'h22, 8'h22, 1'b1, 8'hC0, 8'h00, 8'hC2, 1'b0}, // R6 compare equal
    {4'd6,  5'd5,  8'h01, 8'h02, 1'b0, 8'h02, 8'hFF, 8'h35, 1'b0}, // R6 compare with carry
    {4'd7,  5'd6,  8'hF0, 8'h8F, 1'b0, 8'h29, 8'h80, 8'h35, 1'b1}, // R7 AND keeps H,C
    {4'd7,  5'd7,  8'h00, 8'h00, 1'b0, 8'h3F, 8'h00, 8'h23, 1'b1}, // R7 OR zero
    {4'd7,  5'd8,  8'hAA, 8'h55, 1'b0, 8'h00, 8'hFF, 8'h14, 1'b1}, // R7 XOR
    {4'd8,  5'd9,  8'h00, 8'h00, 1'b0, 8'h00, 8'hFF, 8'h15, 1'b1}, // R8 complement
    {4'd9,  5'd10, 8'h80, 8'h00, 1'b0, 8'h00, 8'h80, 8'h0D, 1'b1}, // R9 negate 0x80
    {4'd9,  5'd10, 8'h00, 8'h00, 1'b0, 8'h01, 8'h00, 8'h02, 1'b1}, // R9 negate zero
    {4'd10, 5'd11, 8'h7F, 8'h00, 1'b0, 8'h01, 8'h80, 8'h0D, 1'b1}, // R10 inc 0x7F
    {4'd10, 5'd12, 8'h80, 8'h00, 1'b0, 8'h20, 8'h7F, 8'h38, 1'b1}, // R10 dec 0x80
    {4'd10, 5'd12, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00, 8'h02, 1'b1}, // R10 dec to zero
    {4'd12, 5'd13, 8'h3C, 8'h00, 1'b0, 8'h5A, 8'hC3, 8'h5A, 1'b1}, // R12 swap
    {4'd11, 5'd14, 8'h81, 8'h00, 1'b0, 8'h00, 8'hC0, 8'h15, 1'b1}, // R11 arithmetic shift
    {4'd11, 5'd15, 8'h01, 8'h00, 1'b0, 8'h00, 8'h00, 8'h1B, 1'b1}, // R11 logical shift
    {4'd11, 5'd16, 8'h02, 8'h00, 1'b1, 8'h00, 8'h81, 8'h0C, 1'b1}, // R11 rotate carry in
    {4'd11, 5'd16, 8'h03, 8'h00, 1'b0, 8'h00, 8'h01, 8'h19, 1'b1}, // R11 rotate carry out
    {4'd13, 5'd31, 8'h55, 8'h11, 1'b1, 8'hA5, 8'h00, 8'hA5, 1'b0}, // R13 unused select
    {4'd2,  5'd0,  8'h01, 8'h01, 1'b0, 8'hC0, 8'h02, 8'hC0, 1'b1}  // R2 I,T carried
  };

  task automatic check(input string tag, input logic [7:0] ar, input logic [7:0] er,
                       input logic [7:0] asr, input logic [7:0] esr,
                       input logic awe, input logic ewe);
    n_checks++;
    if (ar !== er || asr !== esr || awe !== ewe) begin
      n_fail++;
      $display("FAIL %s: result %h sr %h we %b, expected result %h sr %h we %b",
               tag, ar, asr, awe, er, esr, ewe);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic cin, input logic [7:0] sin);
    op_sel = op; opnd_a = a; opnd_b = b; carry_in = cin; status_in = sin;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    status_in = 8'hFF; opnd_a = 8'h12; op_sel = 5'd0;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    check("R1 reset state", result_q, 8'h00, status_q, 8'h00, wr_en_q, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [50:0] v;
      v = VECS[i];
      apply(v[46:42], v[41:34], v[33:26], v[25], v[24:17]);
      check($sformatf("R%0d vector %0d", v[50:47], i),
            result_q, v[16:9], status_q, v[8:1], wr_en_q, v[0]);
    end

    // R13: the lowest unused select code.
    apply(5'd17, 8'hF0, 8'h0F, 1'b0, 8'h3C);
    check("R13 select 17", result_q, 8'h00, status_q, 8'h3C, wr_en_q, 1'b0);

    // R1: outputs hold the last result until the next clock edge.
    apply(5'd7, 8'h0F, 8'hF0, 1'b0, 8'h00);
    op_sel = 5'd13; opnd_a = 8'h00; status_in = 8'h77;
    #1;
    check("R1 latency hold", result_q, 8'hFF, status_q, 8'h14, wr_en_q, 1'b1);
    @(negedge clk);
    check("R1 latency update", result_q, 8'h00, status_q, 8'h77, wr_en_q, 1'b1);

    // R1: a synchronous reset in mid-run clears all outputs.
    rst = 1'b1;
    apply(5'd0, 8'h01, 8'h02, 1'b0, 8'hC0);
    check("R1 reset mid-run", result_q, 8'h00, status_q, 8'h00, wr_en_q, 1'b0);
    rst = 1'b0;
    apply(5'd0, 8'h01, 8'h02, 1'b0, 8'hC0);
    check("R1 after reset", result_q, 8'h03, status_q, 8'hC0, wr_en_q, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule